// File: doc/BRIEF.md
# Successive-Approximation Conversion and Serial Readout Sequencer

This block is the digital control for a 16-bit successive-approximation converter. The converter's own data clock drives it, and an active-low chip select frames each conversion. When chip select falls, the block holds a sample-enable output high for an acquisition window. It then tests one trial code per clock on a DAC-code output and reads a single comparator input to decide each bit. A decided bit goes onto the serial data output in the same clock edge that decides it, so the stream has no latency. After the least significant bit, the word is sent again in reverse order. The output then releases and the block stays quiet until chip select is raised.

All sequencing takes place on the falling edge of the data clock, so a receiver can capture each bit on the following rising edge. There are two power-down indications. One is a partial power-down for the analog section, which starts once the last bit is decided. The other is a full shutdown, which holds for as long as chip select is high. Raising chip select at any moment aborts the frame at once. This lets a host stop early when the leading bits are all it needs.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` and `sample_en` are 0, `pd_full` and `pd_analog` are 1, and the sequencer returns to its idle (count zero) state without waiting for a clock.
- R2: From the fall of `cs_n` until the 5th falling `dclk` edge, `sample_en` is 1 and `sdo_oe` is 0. `sample_en` is 0 from the 5th falling edge onward.
- R3: After the 5th falling edge, `sdo_oe` is 1 and `sdo_d` carries a single 0 bit (the null bit) for one clock.
- R4: The first trial code on `dac_code` is 0x8000. Each tested bit is kept when `cmp_ge` is 1, meaning the input is at or above the trial level, and the next lower bit is then set. The decided word is the straight-binary code floor(Vin·65536/Vref).
- R5: After falling edges 6 through 21, `sdo_d` shows bits 15 down to 0, in that order. Each bit appears after the same edge at which `cmp_ge` decides it.
- R6: After falling edges 22 through 36, `sdo_d` shows bits 1 up to 15, in that order (least significant bit first, with bit 0 not repeated).
- R7: From the 37th falling edge on, `sdo_oe` is 0. Further clocks change no output until `cs_n` rises.
- R8: `pd_analog` rises after the 21st falling edge, when bit 0 is decided, and stays 1 for the rest of the frame. `pd_full` equals `cs_n`.
- R9: Raising `cs_n` mid-frame clears `sdo_oe` at once. The next frame's result does not depend on the aborted one.
- R10: An active-low asynchronous `rst_n` clears the sequencer. While it is low, `sdo_oe` and `sample_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock; the sequence advances on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high aborts and shuts down |
| cmp_ge | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| dac_code | output | 16 | Trial code applied to the capacitor DAC |
| sample_en | output | 1 | High during the acquisition window |
| sdo_d | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial output enable; 0 means high impedance |
| pd_analog | output | 1 | Analog section power-down |
| pd_full | output | 1 | Full shutdown |

## Verification
The assertions assume that `cs_n` and `rst_n` change away from the falling `dclk` edge. They also assume that `cmp_ge` settles to a pure function of `dac_code` and a held input code within one clock. The bench meets both assumptions. It drives `cs_n`, `rst_n` and the ideal input code just after a rising edge, and it models the comparator as a combinational greater-or-equal of that code against `dac_code`. The code is held constant for the whole of each frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    PH_ACQ  = 3'd0,
    PH_NULL = 3'd1,
    PH_CONV = 3'd2,
    PH_ECHO = 3'd3,
    PH_DONE = 3'd4
  } phase_t;

  // Phase from the number of falling edges since chip select fell.
  function automatic phase_t phase_of(input int cnt, input int acq, input int nb);
    if (cnt < acq)               return PH_ACQ;
    else if (cnt == acq)         return PH_NULL;
    else if (cnt <= acq + nb)    return PH_CONV;
    else if (cnt < acq + 2 * nb) return PH_ECHO;
    else                         return PH_DONE;
  endfunction

  // Bit under test while the count is in the trial range.
  function automatic int trial_bit(input int cnt, input int acq, input int nb);
    return acq + nb - 1 - cnt;
  endfunction

  // Bit shown on the serial line for a given count.
  function automatic int out_bit(input int cnt, input int acq, input int nb);
    if (cnt <= acq + nb) return acq + nb - cnt;
    else                 return cnt - (acq + nb);
  endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS     = 16,
  parameter int unsigned ACQ_EDGES = 5,
  parameter int unsigned CW        = 6
) (
  input  logic          clk,
  input  logic          arst_n,
  output logic [CW-1:0] cnt,
  output phase_t        phase,
  output logic          conv_done
);
  localparam int unsigned END_CNT = ACQ_EDGES + 2 * NBITS;
  localparam logic [CW-1:0] END_C  = CW'(END_CNT);
  localparam logic [CW-1:0] DONE_C = CW'(ACQ_EDGES + NBITS);

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n)
      cnt <= '0;
    else if (cnt != END_C)
      cnt <= cnt + 1'b1;
  end

  always_comb begin
    phase     = phase_of(int'(cnt), int'(ACQ_EDGES), int'(NBITS));
    conv_done = (cnt >= DONE_C);
  end
endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS     = 16,
  parameter int unsigned ACQ_EDGES = 5,
  parameter int unsigned CW        = 6,
  parameter int unsigned KW        = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [CW-1:0]    cnt,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result,
  output logic             testing
);
  localparam logic [CW-1:0] T_FIRST = CW'(ACQ_EDGES);
  localparam logic [CW-1:0] T_LAST  = CW'(ACQ_EDGES + NBITS - 1);

  logic [KW-1:0]    k;
  logic [NBITS-1:0] probe;

  always_comb begin
    testing = (cnt >= T_FIRST) && (cnt <= T_LAST);
    k       = KW'(trial_bit(int'(cnt), int'(ACQ_EDGES), int'(NBITS)));
    probe   = testing ? (NBITS'(1) << k) : '0;
    trial   = result | probe;
  end

  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n)
      result <= '0;
    else if (testing && cmp_ge)
      result <= result | probe;
  end
endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS     = 16,
  parameter int unsigned ACQ_EDGES = 5,
  parameter int unsigned CW        = 6,
  parameter int unsigned KW        = 4
) (
  input  logic [CW-1:0]    cnt,
  input  phase_t           phase,
  input  logic [NBITS-1:0] result,
  output logic             drive,
  output logic             bit_val
);
  logic [KW-1:0] idx;

  always_comb begin
    idx     = KW'(out_bit(int'(cnt), int'(ACQ_EDGES), int'(NBITS)));
    drive   = (phase == PH_NULL) || (phase == PH_CONV) || (phase == PH_ECHO);
    bit_val = ((phase == PH_CONV) || (phase == PH_ECHO)) ? result[idx] : 1'b0;
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned NBITS     = 16,
  parameter int unsigned ACQ_EDGES = 5
) (
  input  logic             dclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] dac_code,
  output logic             sample_en,
  output logic             sdo_d,
  output logic             sdo_oe,
  output logic             pd_analog,
  output logic             pd_full
);
  localparam int unsigned END_CNT = ACQ_EDGES + 2 * NBITS;
  localparam int unsigned CW      = $clog2(END_CNT + 1);
  localparam int unsigned KW      = $clog2(NBITS);

  logic          arst_n;
  logic [CW-1:0] cnt;
  phase_t        phase;
  logic          conv_done;
  logic          testing;
  logic          drive;
  logic          bit_val;
  logic [NBITS-1:0] result;

  // Named events for the checker.
  logic          first_trial;
  logic          active;

  assign arst_n = rst_n & ~cs_n;
  assign active = rst_n & ~cs_n;

  sar_seq_timer #(.NBITS(NBITS), .ACQ_EDGES(ACQ_EDGES), .CW(CW)) u_timer (
    .clk      (dclk),
    .arst_n   (arst_n),
    .cnt      (cnt),
    .phase    (phase),
    .conv_done(conv_done)
  );

  sar_seq_trial #(.NBITS(NBITS), .ACQ_EDGES(ACQ_EDGES), .CW(CW), .KW(KW)) u_trial (
    .clk    (dclk),
    .arst_n (arst_n),
    .cnt    (cnt),
    .cmp_ge (cmp_ge),
    .trial  (dac_code),
    .result (result),
    .testing(testing)
  );

  sar_seq_out #(.NBITS(NBITS), .ACQ_EDGES(ACQ_EDGES), .CW(CW), .KW(KW)) u_out (
    .cnt    (cnt),
    .phase  (phase),
    .result (result),
    .drive  (drive),
    .bit_val(bit_val)
  );

  always_comb begin
    first_trial = (phase == PH_NULL) && active;
    sample_en   = (phase == PH_ACQ) && active;
    sdo_oe      = drive && active;
    sdo_d       = bit_val && active;
    pd_full     = cs_n;
    pd_analog   = cs_n | (conv_done & rst_n);
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned NBITS = 16
) (
  input logic             dclk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [NBITS-1:0] dac_code,
  input logic             sample_en,
  input logic             sdo_oe,
  input logic             pd_analog,
  input logic             pd_full,
  input logic             first_trial
);
  localparam logic [NBITS-1:0] MID = {1'b1, {(NBITS-1){1'b0}}};

  // R1
  always_comb begin
    if (rst_n === 1'b1 && cs_n === 1'b1)
      cs_idle_chk: assert (!sdo_oe && !sample_en && pd_full && pd_analog);
  end

  // R2
  sample_excl_chk: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
    sample_en |-> (!sdo_oe && !pd_analog));

  // R4
  first_trial_chk: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
    first_trial |-> (dac_code == MID));

  // R7
  tri_hold_chk: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
    $fell(sdo_oe) |=> !sdo_oe);

  // R8
  pd_sticky_chk: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
    pd_analog |=> pd_analog);

  // R8
  dac_frozen_chk: assert property (@(negedge dclk) disable iff (!rst_n || cs_n)
    (pd_analog && $past(pd_analog)) |-> $stable(dac_code));
endmodule

bind sar_serial_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .dclk       (dclk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .dac_code   (dac_code),
  .sample_en  (sample_en),
  .sdo_oe     (sdo_oe),
  .pd_analog  (pd_analog),
  .pd_full    (pd_full),
  .first_trial(first_trial)
);

// File: tb/sim_sar_serial_seq.sv
`timescale 1ns/1ps
module sim_sar_serial_seq;
  logic        dclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [15:0] vin = 16'h0;
  logic        cmp_ge;
  logic [15:0] dac_code;
  logic        sample_en, sdo_d, sdo_oe, pd_analog, pd_full;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 dclk = ~dclk;

  // Behavioural comparator: input at or above trial level.
  assign cmp_ge = (vin >= dac_code);

  sar_serial_seq u0 (
    .dclk(dclk), .rst_n(rst_n), .cs_n(cs_n), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .sample_en(sample_en), .sdo_d(sdo_d),
    .sdo_oe(sdo_oe), .pd_analog(pd_analog), .pd_full(pd_full)
  );

  localparam logic [15:0] VEC [0:7] = '{
    16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
    16'h1234, 16'hA5A5, 16'h0001, 16'hFFFE
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One falling edge, then sample just after the next rising edge.
  task automatic step();
    @(negedge dclk);
    @(posedge dclk);
    #1;
  endtask

  task automatic check_idle(input string tag);
    chk(tag, {28'h0, sdo_oe, sample_en, pd_full, pd_analog}, {28'h0, 4'b0011});
  endtask

  // Run a frame for 'edges' falling edges, checking every step.
  task automatic frame(input logic [15:0] v, input int edges);
    logic [15:0] word;
    word = 16'h0;
    @(posedge dclk); #1;
    vin  = v;
    cs_n = 1'b0;
    #1;
    chk("R2 sample at cs fall", {31'h0, sample_en}, 32'h1);
    for (int e = 1; e <= edges; e++) begin
      logic       xs, xo, xd;
      string      tag;
      step();
      xs = (e < 5);
      xo = (e >= 5) && (e <= 36);
      xd = 1'b0;
      tag = "R7 tail";
      if (e < 5) tag = "R2 acquire";
      else if (e == 5) tag = "R3 null";
      else if (e <= 21) begin tag = "R5 msb first"; xd = v[21-e]; word[21-e] = sdo_d; end
      else if (e <= 36) begin tag = "R6 lsb echo"; xd = v[e-21]; end
      chk(tag, {29'h0, xs, xo, xd}, {29'h0, sample_en, sdo_oe, sdo_d});
      chk("R8 analog pd", {31'h0, pd_analog}, {31'h0, (e >= 21)});
      if (e == 5) chk("R4 first trial", {16'h0, dac_code}, 32'h8000);
    end
    if (edges >= 21) chk("R4 word", {16'h0, word}, {16'h0, v});
  endtask

  initial begin
    #3;
    check_idle("R10 reset with cs high");
    rst_n = 1'b1;
    #2;
    check_idle("R1 idle");
    chk("R8 full pd", {31'h0, pd_full}, 32'h1);

    for (int i = 0; i < 8; i++) begin
      frame(VEC[i], (i == 0) ? 45 : 38);
      cs_n = 1'b1;
      #1;
      check_idle("R1 after frame");
    end

    // R9: abort after b10 has been shown, then a clean frame.
    frame(16'hBEEF, 11);
    chk("R9 bits before abort", {31'h0, sdo_oe}, 32'h1);
    cs_n = 1'b1;
    #1;
    chk("R9 abort tri", {31'h0, sdo_oe}, 32'h0);
    check_idle("R9 abort idle");
    frame(16'h4321, 37);
    cs_n = 1'b1;
    #1;

    // R10: asynchronous reset mid-frame.
    frame(16'h5A5A, 8);
    rst_n = 1'b0;
    #1;
    chk("R10 reset mid-frame", {30'h0, sdo_oe, sample_en}, 32'h0);
    cs_n = 1'b1;
    #1;
    rst_n = 1'b1;
    #1;
    frame(16'h00FF, 37);
    cs_n = 1'b1;
    #1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule